// File: doc/BRIEF.md
# SPI Receive Holding Register with Overrun Freeze

This block sits behind the serial shifter of an SPI peripheral and owns the receive side of the data path. Each time the shifter reports a finished character, the block decides whether that character may enter the single holding register. It keeps a "receive full" flag and an "overrun" flag. From those flags it drives a level request to a DMA engine and an interrupt line to the CPU.

If a character finishes while the previous one is still unread, the new character is dropped and the overrun flag is raised. From then on the receiver stays frozen until software clears the overrun. While frozen, it discards every further character, stops loading the holding register and withholds DMA requests, even if the holding register has been drained.

Software clears the overrun in two steps: a status read that sees the flag set, and then a read of the holding register. A separate error-interrupt enable lets the overrun reach the CPU even when DMA is servicing the full flag.

Top module: `spi_rx_buffer`

## Requirements
- R1: When `char_done` pulses with `rx_full` low and `rx_ovr` low, `char_in` appears on `rx_data` and `rx_full` is 1 on the cycle after the clock edge.
- R2: A `data_rd` pulse with no character accepted in the same cycle clears `rx_full` at the next edge.
- R3: A `char_done` pulse while `rx_full` is 1, with no `data_rd` that cycle and `rx_ovr` low, sets `rx_ovr` at the next edge and leaves `rx_data` unchanged.
- R4: While `rx_ovr` is 1, completed characters never load `rx_data` and never set `rx_full`, including after `rx_full` has been cleared.
- R5: `rx_ovr` is cleared by a `data_rd` that follows an earlier `stat_rd` taken while `rx_ovr` was 1. The flag reads 0 from the edge that samples that `data_rd`.
- R6: A `stat_rd` taken while `rx_ovr` is 0 does not arm the clearing sequence. An overrun raised after such a status read survives the following `data_rd`.
- R7: `dma_req` equals `rx_full AND dma_en AND NOT rx_ovr AND NOT data_rd`, combinationally, in the same cycle.
- R8: With the default `REG_IRQ = 0`, `irq` equals `(rx_full AND NOT dma_en AND rx_irq_en) OR (rx_ovr AND err_irq_en)` in the same cycle.
- R9: When `char_done` and `data_rd` occur in the same cycle, the read wins. The new character is loaded, `rx_full` stays 1 and `rx_ovr` stays 0.
- R10: During and after reset, `rx_full`, `rx_ovr`, `rx_data`, `dma_req` and `irq` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| char_done | input | 1 | One-cycle strobe: shifter has a finished character |
| char_in | input | DATA_W | Character from the shifter |
| data_rd | input | 1 | Holding-register read strobe (CPU or DMA) |
| stat_rd | input | 1 | Status-register read strobe |
| dma_en | input | 1 | Route the full flag to the DMA request instead of the CPU |
| rx_irq_en | input | 1 | Enable CPU interrupt for the full flag |
| err_irq_en | input | 1 | Enable CPU interrupt for overrun |
| rx_data | output | DATA_W | Holding register |
| rx_full | output | 1 | Receive-full flag |
| rx_ovr | output | 1 | Overrun flag |
| dma_req | output | 1 | Level DMA service request |
| irq | output | 1 | CPU interrupt request |

## Verification
Two events can fall in the same cycle: a finished character arriving, and a read of the holding register. The bench raises `char_done` and `data_rd` in one cycle while the register is full. It expects the new character to be loaded with no overrun. It also issues the full-register case without a read and expects an overrun instead. The second collision is between the clearing sequence and a new overrun. The bench does a status read while the overrun flag is clear, then forces an overrun, then reads the data register, and it judges that the overrun is still set.

// File: rtl/spi_rx_pkg.sv
package spi_rx_pkg;

   typedef struct packed {
      logic full;
      logic ovr;
   } rx_flags_t;

   function automatic logic accept_char(input logic done, input rx_flags_t f,
                                        input logic rd);
      return done && !f.ovr && (!f.full || rd);
   endfunction

endpackage

// File: rtl/rx_hold_reg.sv
module rx_hold_reg
   import spi_rx_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  logic              rd,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] dout,
   output logic              full
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dout <= '0;
         full <= 1'b0;
      end else if (accept) begin
         dout <= din;
         full <= 1'b1;
      end else if (rd) begin
         full <= 1'b0;
      end
   end

endmodule

// File: rtl/rx_ovr_track.sv
module rx_ovr_track (
   input  logic clk,
   input  logic rst_n,
   input  logic done,
   input  logic full,
   input  logic rd,
   input  logic srd,
   output logic ovr
);

   logic armed;
   logic set_ovr;
   logic clr_ovr;

   assign set_ovr = done && full && !rd && !ovr;
   assign clr_ovr = ovr && armed && rd;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ovr <= 1'b0;
      end else if (set_ovr) begin
         ovr <= 1'b1;
      end else if (clr_ovr) begin
         ovr <= 1'b0;
      end
   end

   // Arming needs a status read that actually saw the flag set.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed <= 1'b0;
      end else if (!ovr) begin
         armed <= 1'b0;
      end else if (srd) begin
         armed <= 1'b1;
      end else if (rd) begin
         armed <= 1'b0;
      end
   end

endmodule

// File: rtl/rx_req_gen.sv
module rx_req_gen #(
   parameter bit REG_IRQ = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic full,
   input  logic ovr,
   input  logic rd,
   input  logic dma_en,
   input  logic rx_ie,
   input  logic err_ie,
   output logic dma_req,
   output logic irq
);

   logic irq_next;

   assign dma_req  = full && dma_en && !ovr && !rd;
   assign irq_next = (full && !dma_en && rx_ie) || (ovr && err_ie);

   generate
      if (REG_IRQ) begin : g_irq_reg
         logic irq_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq_q <= 1'b0;
            else        irq_q <= irq_next;
         end
         assign irq = irq_q;
      end else begin : g_irq_comb
         assign irq = irq_next;
      end
   endgenerate

endmodule

// File: rtl/spi_rx_buffer.sv
module spi_rx_buffer
   import spi_rx_pkg::*;
#(
   parameter int DATA_W  = 8,
   parameter bit REG_IRQ = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              char_done,
   input  logic [DATA_W-1:0] char_in,
   input  logic              data_rd,
   input  logic              stat_rd,
   input  logic              dma_en,
   input  logic              rx_irq_en,
   input  logic              err_irq_en,
   output logic [DATA_W-1:0] rx_data,
   output logic              rx_full,
   output logic              rx_ovr,
   output logic              dma_req,
   output logic              irq
);

   generate
      if (DATA_W < 1 || DATA_W > 64) begin : g_bad_width
         $error("spi_rx_buffer: DATA_W out of range");
      end
   endgenerate

   rx_flags_t flags;
   logic      accept;

   assign flags.full = rx_full;
   assign flags.ovr  = rx_ovr;
   assign accept     = accept_char(char_done, flags, data_rd);

   rx_hold_reg #(.DATA_W(DATA_W)) u_hold (
      .clk  (clk),
      .rst_n(rst_n),
      .accept(accept),
      .rd   (data_rd),
      .din  (char_in),
      .dout (rx_data),
      .full (rx_full)
   );

   rx_ovr_track u_ovr (
      .clk  (clk),
      .rst_n(rst_n),
      .done (char_done),
      .full (rx_full),
      .rd   (data_rd),
      .srd  (stat_rd),
      .ovr  (rx_ovr)
   );

   rx_req_gen #(.REG_IRQ(REG_IRQ)) u_req (
      .clk    (clk),
      .rst_n  (rst_n),
      .full   (rx_full),
      .ovr    (rx_ovr),
      .rd     (data_rd),
      .dma_en (dma_en),
      .rx_ie  (rx_irq_en),
      .err_ie (err_irq_en),
      .dma_req(dma_req),
      .irq    (irq)
   );

endmodule

// File: rtl/spi_rx_buffer_chk.sv
module spi_rx_buffer_chk #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              char_done,
   input logic [DATA_W-1:0] char_in,
   input logic              data_rd,
   input logic              rx_full,
   input logic              rx_ovr,
   input logic [DATA_W-1:0] rx_data,
   input logic              dma_req
);

   // R1
   load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      char_done && !rx_ovr && !rx_full |=> rx_full && rx_data == $past(char_in));

   // R2
   rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      data_rd && !char_done |=> !rx_full);

   // R3
   overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      char_done && rx_full && !data_rd && !rx_ovr |=> rx_ovr && $stable(rx_data));

   // R4
   frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_ovr && char_done |=> $stable(rx_data));

   // R5
   ovr_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rx_ovr) |-> $past(data_rd));

   // R7
   no_dma_in_ovr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_ovr || data_rd |-> !dma_req);

   // R9
   collide_chk: assert property (@(posedge clk) disable iff (!rst_n)
      char_done && data_rd && !rx_ovr |=> rx_full && !rx_ovr);

endmodule

bind spi_rx_buffer spi_rx_buffer_chk #(.DATA_W(DATA_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .char_done(char_done),
   .char_in  (char_in),
   .data_rd  (data_rd),
   .rx_full  (rx_full),
   .rx_ovr   (rx_ovr),
   .rx_data  (rx_data),
   .dma_req  (dma_req)
);

// File: tb/spi_rx_buffer_test.sv
module spi_rx_buffer_test;

   localparam int W = 8;

   typedef struct {
      string      tag;
      logic       full;
      logic       ovr;
      logic [W-1:0] data;
   } exp_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic char_done = 1'b0, data_rd = 1'b0, stat_rd = 1'b0;
   logic dma_en = 1'b0, rx_irq_en = 1'b0, err_irq_en = 1'b0;
   logic [W-1:0] char_in = '0;
   logic [W-1:0] rx_data;
   logic rx_full, rx_ovr, dma_req, irq;

   int checks = 0, errors = 0;
   bit done = 0;
   exp_t q[$];

   // reference state
   logic m_full = 0, m_ovr = 0, m_arm = 0;
   logic [W-1:0] m_data = '0;

   always #5 clk = ~clk;

   spi_rx_buffer uut (
      .clk(clk), .rst_n(rst_n), .char_done(char_done), .char_in(char_in),
      .data_rd(data_rd), .stat_rd(stat_rd), .dma_en(dma_en),
      .rx_irq_en(rx_irq_en), .err_irq_en(err_irq_en), .rx_data(rx_data),
      .rx_full(rx_full), .rx_ovr(rx_ovr), .dma_req(dma_req), .irq(irq)
   );

   task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   // monitor: pops expected flag/data items after each edge
   always @(posedge clk) begin
      #2;
      if (q.size() > 0) begin
         exp_t e;
         e = q.pop_front();
         chk({e.tag, " full"}, rx_full, e.full);
         chk({e.tag, " ovr"},  rx_ovr,  e.ovr);
         chk({e.tag, " data"}, rx_data, e.data);
      end
   end

   // driver: one cycle of stimulus, pushes the predicted result
   task automatic cyc(string tag, logic bd, logic [W-1:0] b, logic rd, logic srd);
      logic acc;
      exp_t e;
      @(negedge clk);
      char_done = bd; char_in = b; data_rd = rd; stat_rd = srd;
      #1;
      chk({tag, " R7 dma_req"}, dma_req, m_full && dma_en && !m_ovr && !rd);
      chk({tag, " R8 irq"}, irq,
          (m_full && !dma_en && rx_irq_en) || (m_ovr && err_irq_en));
      acc = bd && !m_ovr && (!m_full || rd);
      if (acc) begin m_data = b; end
      if (bd && !m_ovr && m_full && !rd) begin
         m_ovr = 1;
         m_arm = 0;
      end else if (m_ovr && m_arm && rd) begin
         m_ovr = 0;
         m_arm = srd;
      end else if (!m_ovr) m_arm = 0;
      else if (srd) m_arm = 1;
      else if (rd) m_arm = 0;
      m_full = acc ? 1'b1 : (rd ? 1'b0 : m_full);
      e.tag = tag; e.full = m_full; e.ovr = m_ovr; e.data = m_data;
      q.push_back(e);
      @(posedge clk);
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R10 rst full", rx_full, 0);
      chk("R10 rst ovr", rx_ovr, 0);
      chk("R10 rst data", rx_data, 0);
      chk("R10 rst dma", dma_req, 0);
      chk("R10 rst irq", irq, 0);
      rst_n = 1;
      rx_irq_en = 1;
      cyc("R1 load", 1, 8'hA5, 0, 0);
      cyc("R8 rx irq", 0, 8'h00, 0, 0);
      cyc("R2 read", 0, 8'h00, 1, 0);
      cyc("R1 load2", 1, 8'h3C, 0, 0);
      cyc("R9 collide", 1, 8'h7E, 1, 0);
      dma_en = 1; err_irq_en = 1;
      cyc("R7 dma high", 0, 8'h00, 0, 0);
      cyc("R3 overrun", 1, 8'h11, 0, 0);
      cyc("R7 dma ovr", 0, 8'h00, 0, 0);
      cyc("R4 drain", 0, 8'h00, 1, 0);
      cyc("R4 drop", 1, 8'h22, 0, 0);
      cyc("R5 stat", 0, 8'h00, 0, 1);
      cyc("R5 clear", 0, 8'h00, 1, 0);
      cyc("R1 after clr", 1, 8'h44, 0, 0);
      cyc("R6 stat clear", 0, 8'h00, 0, 1);
      cyc("R6 overrun", 1, 8'h55, 0, 0);
      cyc("R6 read keeps", 0, 8'h00, 1, 0);
      cyc("R4 stays", 1, 8'h66, 0, 0);
      cyc("R5 stat2", 0, 8'h00, 0, 1);
      cyc("R5 clear2", 0, 8'h00, 1, 0);
      dma_en = 0;
      cyc("R1 load3", 1, 8'h99, 0, 0);
      cyc("R2 read3", 0, 8'h00, 1, 0);
      cyc("idle", 0, 8'h00, 0, 0);
      repeat (2) @(negedge clk);
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule